// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. On every strobed operation it takes the accumulator byte and a second byte, which is either the addressed data-memory byte or an immediate. It forms an 8-bit result and says where that result is to be written: the accumulator or the memory operand. It also updates a registered status word holding zero (Z), carry (C), half carry (AC) and signed overflow (OV).

The instruction decoder drives an already decoded operation code, an immediate select and a memory-destination select. The result and the two write enables are combinational, so the caller writes them on the same clock edge that loads the new flags. Each operation class touches only its own subset of the flags. The other flags carry over unchanged, which lets multi-byte and decimal sequences chain through the stored carry.

Top module: `acc_alu`

## Requirements
- R1: `op_code` encoding: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 decimal adjust, 5 AND, 6 OR, 7 XOR, 8 complement, 9 increment, 10 decrement. Add-type results are A+B (code 0) and A+B+C (code 1), where C is the stored carry.
- R2: Subtract is A + ~B + 1. Subtract with carry is A + ~B + C, where C is the stored carry. A stored C of 1 means no borrow occurred.
- R3: For codes 0–3, C becomes the carry out of bit 7, AC the carry out of bit 3, and OV the XOR of the carries into and out of bit 7.
- R4: AND, OR and XOR combine the accumulator with the second operand. Complement inverts the memory byte. These four update only Z; C, AC and OV keep their values.
- R5: Increment and decrement act on the memory byte, wrapping modulo 256. They update only Z.
- R6: Decimal adjust works on the accumulator. It adds 0x06 if the low nibble exceeds 9 or AC is set. It then adds 0x60 if that step carried, the high nibble exceeds 9, or C is set. It sets C when either addition carries out, and otherwise leaves C unchanged. Z, AC and OV keep their values.
- R7: Every operation except decimal adjust sets Z exactly when its 8-bit result is zero.
- R8: A valid operation raises exactly one of `wr_acc` and `wr_mem`. Decimal adjust always targets memory. When `use_imm` is high, codes 0–3 and 5–7 take the immediate and target the accumulator, whatever `to_mem` says. Otherwise `to_mem`=1 selects memory.
- R9: With `op_valid` low, or with a code of 11–15, both write enables stay low and no flag changes.
- R10: A synchronous active-high `rst` clears all four flags on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Decoded operation (see R1) |
| use_imm | input | 1 | Take second operand from `imm_in` |
| to_mem | input | 1 | Send result to the memory operand |
| acc_in | input | 8 | Accumulator value |
| mem_in | input | 8 | Addressed data-memory byte |
| imm_in | input | 8 | Immediate byte |
| result | output | 8 | Operation result |
| wr_acc | output | 1 | Write result to accumulator |
| wr_mem | output | 1 | Write result to memory operand |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry / no-borrow flag |
| flag_ac | output | 1 | Stored half-carry flag |
| flag_ov | output | 1 | Stored signed-overflow flag |

## Verification
The bench chains operations, so flags left by one step feed the next. A design that cleared carry on a logic operation, or that ignored the stored carry in add-with-carry or subtract-with-carry, would then give wrong sums later in the run. Decimal adjust is driven on 0x3C, on 0x9A (which must wrap to 0x00 with carry set) and on 0x00 with carry already set, where a design that clears carry would drop it. Immediate forms are issued with the memory select high, and a design that trusted that select would write memory. The 0x7F+1 and 0x80−1 cases expose a wrong overflow or half-carry tap, and an undefined code shows whether the design writes or moves flags when it should not.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_DAA = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_CPL = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10
    } alu_op_e;

    // bit order z,c,ac,ov -> [3],[2],[1],[0]
    typedef struct packed {
        logic z;
        logic c;
        logic ac;
        logic ov;
    } flags_t;

    localparam int FLAG_N = $bits(flags_t);

    function automatic logic code_legal(logic [CODE_W-1:0] code);
        return code <= CODE_W'(OP_DEC);
    endfunction

    function automatic logic imm_capable(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_AND, OP_OR, OP_XOR: return 1'b1;
            default:               return 1'b0;
        endcase
    endfunction

    function automatic flags_t update_mask(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: return '{z:1'b1, c:1'b1, ac:1'b1, ov:1'b1};
            OP_DAA:                         return '{z:1'b0, c:1'b1, ac:1'b0, ov:1'b0};
            OP_AND, OP_OR, OP_XOR,
            OP_CPL, OP_INC, OP_DEC:         return '{z:1'b1, c:1'b0, ac:1'b0, ov:1'b0};
            default:                        return '0;
        endcase
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
    import acc_alu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int HALF = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         half_c,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;
    logic         c_into_msb;

    always_comb begin
        b_eff      = invert_b ? ~b : b;
        full       = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum        = full[W-1:0];
        c_out      = full[W];
        // carry into a bit position = a ^ b ^ sum at that position
        half_c     = a[HALF] ^ b_eff[HALF] ^ full[HALF];
        c_into_msb = a[W-1] ^ b_eff[W-1] ^ full[W-1];
        ovf        = c_into_msb ^ full[W];
    end
endmodule

// File: rtl/acc_alu_bcd_fix.sv
module acc_alu_bcd_fix
    import acc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  logic              half_c,
    input  logic              carry,
    output logic [DATA_W-1:0] fixed,
    output logic              c_gen
);
    localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
    localparam logic [DATA_W:0]  LO_ADJ    = (DATA_W+1)'(6);
    localparam logic [DATA_W:0]  HI_ADJ    = (DATA_W+1)'(6) << NIB_W;

    logic [DATA_W:0] step_lo;
    logic [DATA_W:0] step_hi;
    logic            lo_fix;
    logic            hi_fix;

    always_comb begin
        lo_fix  = (acc[NIB_W-1:0] > DIGIT_MAX) | half_c;
        step_lo = {1'b0, acc} + (lo_fix ? LO_ADJ : '0);
        hi_fix  = step_lo[DATA_W] | (step_lo[DATA_W-1:NIB_W] > DIGIT_MAX) | carry;
        step_hi = {1'b0, step_lo[DATA_W-1:0]} + (hi_fix ? HI_ADJ : '0);
        fixed   = step_hi[DATA_W-1:0];
        c_gen   = step_lo[DATA_W] | step_hi[DATA_W];
    end
endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status
    import acc_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd,
    input  flags_t mask,
    input  flags_t nxt,
    output flags_t q
);
    logic [FLAG_N-1:0] q_bits;
    logic [FLAG_N-1:0] m_bits;
    logic [FLAG_N-1:0] n_bits;

    assign m_bits = mask;
    assign n_bits = nxt;
    assign q      = q_bits;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q_bits[i] <= 1'b0;
            else if (upd && m_bits[i])
                q_bits[i] <= n_bits[i];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q_bits == '0)); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(q_bits)); // R9
    AST_UNMASKED_C_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (upd && !mask.c) |=> $stable(q_bits[2])); // R4
    AST_UNMASKED_OV_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (upd && !mask.ov) |=> $stable(q_bits[0])); // R5
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [CODE_W-1:0] op_code,
    input  logic              use_imm,
    input  logic              to_mem,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] mem_in,
    input  logic [DATA_W-1:0] imm_in,
    output logic [DATA_W-1:0] result,
    output logic              wr_acc,
    output logic              wr_mem,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_ac,
    output logic              flag_ov
);
    alu_op_e           op;
    logic              legal;
    logic              go;
    logic              imm_form;
    logic              mem_dest;
    logic [DATA_W-1:0] opnd_b;
    logic              is_sub;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_c;
    logic              add_ac;
    logic              add_ov;
    logic [DATA_W-1:0] bcd_val;
    logic              bcd_c;
    flags_t            flags_q;
    flags_t            flags_d;
    logic [DATA_W-1:0] res;

    assign op       = alu_op_e'(op_code);
    assign legal    = code_legal(op_code);
    assign go       = op_valid & legal;
    assign imm_form = use_imm & imm_capable(op);
    assign opnd_b   = imm_form ? imm_in : mem_in;
    assign is_sub   = (op == OP_SUB) || (op == OP_SBC);

    always_comb begin
        case (op)
            OP_ADD:  add_cin = 1'b0;
            OP_SUB:  add_cin = 1'b1;
            default: add_cin = flags_q.c;
        endcase
    end

    acc_alu_adder #(.W(DATA_W), .HALF(NIB_W)) u_adder (
        .a        (acc_in),
        .b        (opnd_b),
        .invert_b (is_sub),
        .cin      (add_cin),
        .sum      (add_sum),
        .c_out    (add_c),
        .half_c   (add_ac),
        .ovf      (add_ov)
    );

    acc_alu_bcd_fix u_bcd (
        .acc    (acc_in),
        .half_c (flags_q.ac),
        .carry  (flags_q.c),
        .fixed  (bcd_val),
        .c_gen  (bcd_c)
    );

    always_comb begin
        flags_d = flags_q;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res        = add_sum;
                flags_d.c  = add_c;
                flags_d.ac = add_ac;
                flags_d.ov = add_ov;
            end
            OP_DAA: begin
                res       = bcd_val;
                flags_d.c = flags_q.c | bcd_c;
            end
            OP_AND:  res = acc_in & opnd_b;
            OP_OR:   res = acc_in | opnd_b;
            OP_XOR:  res = acc_in ^ opnd_b;
            OP_CPL:  res = ~mem_in;
            OP_INC:  res = mem_in + DATA_W'(1);
            OP_DEC:  res = mem_in - DATA_W'(1);
            default: res = '0;
        endcase
        flags_d.z = (res == '0);
    end

    assign mem_dest = (op == OP_DAA) | (to_mem & ~imm_form);
    assign wr_mem   = go & mem_dest;
    assign wr_acc   = go & ~mem_dest;
    assign result   = res;

    acc_alu_status u_status (
        .clk  (clk),
        .rst  (rst),
        .upd  (go),
        .mask (update_mask(op)),
        .nxt  (flags_d),
        .q    (flags_q)
    );

    assign flag_z  = flags_q.z;
    assign flag_c  = flags_q.c;
    assign flag_ac = flags_q.ac;
    assign flag_ov = flags_q.ov;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_code <= 4'd10) |-> (wr_acc ^ wr_mem)); // R8
    AST_IMM_NOT_MEM: assert property (@(posedge clk) disable iff (rst)
        (use_imm && (op_code <= 4'd3 || (op_code >= 4'd5 && op_code <= 4'd7))) |-> !wr_mem); // R8
    AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op_code > 4'd10) |-> !(wr_acc || wr_mem)); // R9
    AST_Z_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code <= 4'd10 && op_code != 4'd4) |=> (flag_z == ($past(result) == '0))); // R7
    AST_DAA_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd4 && flag_c) |=> flag_c); // R6
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [3:0] op_code;
    logic       use_imm;
    logic       to_mem;
    logic [7:0] acc_in;
    logic [7:0] mem_in;
    logic [7:0] imm_in;
    logic [7:0] result;
    logic       wr_acc;
    logic       wr_mem;
    logic       flag_z;
    logic       flag_c;
    logic       flag_ac;
    logic       flag_ov;

    int checks = 0;
    int errors = 0;
    int ez = 0, ec = 0, eac = 0, eov = 0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .use_imm(use_imm), .to_mem(to_mem), .acc_in(acc_in), .mem_in(mem_in),
        .imm_in(imm_in), .result(result), .wr_acc(wr_acc), .wr_mem(wr_mem),
        .flag_z(flag_z), .flag_c(flag_c), .flag_ac(flag_ac), .flag_ov(flag_ov)
    );

    // {code, use_imm, to_mem, acc, mem, imm}
    localparam logic [29:0] VEC [18] = '{
        {4'd0,  1'b0, 1'b0, 8'h7F, 8'h01, 8'h00},
        {4'd1,  1'b1, 1'b0, 8'hFF, 8'h00, 8'h01},
        {4'd1,  1'b0, 1'b0, 8'h10, 8'h20, 8'h00},
        {4'd2,  1'b1, 1'b1, 8'h05, 8'h33, 8'h05},
        {4'd3,  1'b0, 1'b1, 8'h10, 8'h01, 8'h00},
        {4'd5,  1'b1, 1'b0, 8'hF0, 8'h00, 8'h0F},
        {4'd6,  1'b0, 1'b1, 8'h0F, 8'h30, 8'h00},
        {4'd7,  1'b1, 1'b1, 8'hAA, 8'h00, 8'hAA},
        {4'd8,  1'b0, 1'b1, 8'h12, 8'h00, 8'h00},
        {4'd8,  1'b1, 1'b0, 8'h12, 8'hFF, 8'h00},
        {4'd9,  1'b0, 1'b0, 8'h00, 8'hFF, 8'h00},
        {4'd10, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00},
        {4'd0,  1'b0, 1'b0, 8'h15, 8'h27, 8'h00},
        {4'd4,  1'b0, 1'b0, 8'h3C, 8'h00, 8'h00},
        {4'd0,  1'b0, 1'b0, 8'h99, 8'h01, 8'h00},
        {4'd4,  1'b1, 1'b0, 8'h9A, 8'h00, 8'h00},
        {4'd3,  1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
        {4'd4,  1'b0, 1'b0, 8'h00, 8'h00, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int code);
        if (code <= 1) return "R1";
        if (code <= 3) return "R2";
        if (code == 4) return "R6";
        if (code <= 8) return "R4";
        return "R5";
    endfunction

    // Reference from the requirements; updates the expected flag state.
    task automatic step(input int code, input bit ui, input bit tm,
                        input int a, input int m, input int i);
        int  b, cin, s, r, c7, t, carry;
        bit  immf, memd, hc;
        string rq;
        immf = ui && (code <= 3 || (code >= 5 && code <= 7));
        b    = immf ? i : m;
        r    = 0;
        rq   = req_of(code);
        if (code <= 3) begin
            if (code >= 2) b = (~b) & 255;
            cin = (code == 0) ? 0 : (code == 2) ? 1 : ec;
            s   = a + b + cin;
            r   = s & 255;
        end else if (code == 4) begin
            t = a;
            if ((t & 15) > 9 || eac != 0) t += 6;
            hc = t > 255;
            t  = t & 255;
            if (hc || (t >> 4) > 9 || ec != 0) t += 8'h60;
            carry = (hc || t > 255) ? 1 : 0;
            r = t & 255;
        end else if (code == 5) r = a & b;
        else if (code == 6) r = a | b;
        else if (code == 7) r = a ^ b;
        else if (code == 8) r = (~m) & 255;
        else if (code == 9) r = (m + 1) & 255;
        else r = (m + 255) & 255;
        memd = (code == 4) || (tm && !immf);

        @(negedge clk);
        op_code = 4'(code); use_imm = ui; to_mem = tm;
        acc_in = 8'(a); mem_in = 8'(m); imm_in = 8'(i); op_valid = 1'b1;
        #1;
        chk(result == 8'(r), rq, "result", result, r);
        chk(wr_mem == memd && wr_acc == !memd, "R8", "dest{acc,mem}",
            {wr_acc, wr_mem}, {!memd, memd});
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        if (code <= 3) begin
            ec  = s >> 8;
            eac = ((a & 15) + (b & 15) + cin) >> 4;
            c7  = ((a & 127) + (b & 127) + cin) >> 7;
            eov = ec ^ c7;
        end else if (code == 4) begin
            ec = ec | carry;
        end
        if (code != 4) ez = (r == 0) ? 1 : 0;
        chk({flag_z, flag_c, flag_ac, flag_ov} == {1'(ez), 1'(ec), 1'(eac), 1'(eov)},
            (code <= 3) ? "R3" : (code == 4) ? "R6" : "R7", "flags{z,c,ac,ov}",
            {flag_z, flag_c, flag_ac, flag_ov}, {1'(ez), 1'(ec), 1'(eac), 1'(eov)});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        ez = 0; ec = 0; eac = 0; eov = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; use_imm = 1'b0; to_mem = 1'b0;
        acc_in = '0; mem_in = '0; imm_in = '0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        chk({flag_z, flag_c, flag_ac, flag_ov} == 4'b0000, "R10", "reset flags",
            {flag_z, flag_c, flag_ac, flag_ov}, 0);

        for (int k = 0; k < 18; k++) begin
            step(int'(VEC[k][29:26]), VEC[k][25], VEC[k][24],
                 int'(VEC[k][23:16]), int'(VEC[k][15:8]), int'(VEC[k][7:0]));
        end

        // R3: hand values, 0x7F + 0x01 = 0x80, C=0 AC=1 OV=1 Z=0
        do_reset();
        step(0, 1'b0, 1'b0, 8'h7F, 8'h01, 0);
        chk({flag_z, flag_c, flag_ac, flag_ov} == 4'b0011, "R3", "7F+01 flags",
            {flag_z, flag_c, flag_ac, flag_ov}, 4'b0011);
        // R2: 0x80 - 0x01 = 0x7F, C=1 (no borrow) AC=0 OV=1
        step(2, 1'b1, 1'b0, 8'h80, 0, 8'h01);
        chk({flag_z, flag_c, flag_ac, flag_ov} == 4'b0101, "R2", "80-01 flags",
            {flag_z, flag_c, flag_ac, flag_ov}, 4'b0101);
        // R6: 0x99 + 0x01 then adjust -> 0x00 with C=1
        step(0, 1'b0, 1'b0, 8'h99, 8'h01, 0);
        step(4, 1'b0, 1'b1, 8'h9A, 0, 0);
        chk(flag_c == 1'b1 && flag_z == 1'b0, "R6", "daa 9A -> C set, Z untouched",
            {flag_z, flag_c}, 2'b01);

        // R9: strobe low, nothing written and flags held
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd5; acc_in = 8'h00; imm_in = 8'h00; use_imm = 1'b1;
        #1;
        chk(!wr_acc && !wr_mem, "R9", "idle writes", {wr_acc, wr_mem}, 0);
        @(posedge clk); #1;
        chk({flag_z, flag_c, flag_ac, flag_ov} == {1'(ez), 1'(ec), 1'(eac), 1'(eov)},
            "R9", "idle flags", {flag_z, flag_c, flag_ac, flag_ov},
            {1'(ez), 1'(ec), 1'(eac), 1'(eov)});
        // R9: undefined code with strobe high
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd13; use_imm = 1'b0; mem_in = 8'h00;
        #1;
        chk(!wr_acc && !wr_mem, "R9", "bad code writes", {wr_acc, wr_mem}, 0);
        @(posedge clk); #1;
        op_valid = 1'b0;
        chk({flag_z, flag_c, flag_ac, flag_ov} == {1'(ez), 1'(ec), 1'(eac), 1'(eov)},
            "R9", "bad code flags", {flag_z, flag_c, flag_ac, flag_ov},
            {1'(ez), 1'(ec), 1'(eac), 1'(eov)});

        // R10: reset mid-run clears set flags
        step(1, 1'b1, 1'b0, 8'hFF, 0, 8'hFF);
        do_reset();
        chk({flag_z, flag_c, flag_ac, flag_ov} == 4'b0000, "R10", "mid-run reset",
            {flag_z, flag_c, flag_ac, flag_ov}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule